// File: doc/BRIEF.md
# Byte-Counted Serial Flash Word Transfer Engine

This block drives a serial flash device over a single-data-line SPI link. The host hands it one 32-bit word together with a length select. The select picks how many bytes of that word are sent, from one to four. The engine frames the transfer with a chip select and sends the chosen bytes on the data-out line, lowest byte first and each byte most significant bit first. While it sends, it collects the same number of bytes from the data-in line.

When the frame closes, the received bytes are placed in the top lanes of a 32-bit receive word. The lanes below them are left as they were. A one-byte command therefore returns its answer in bits [31:24]. A command followed by a dummy byte returns its status byte in bits [31:24] and the byte captured during the command in [23:16].

Each host write is one complete flash transaction. A write that arrives while a frame is running is dropped and recorded in a sticky overflow flag. The serial clock runs at the system clock divided by an even number set by a half-period input.

Top module: `spi_word_packer`

## Requirements
- R1: After reset: spi_cs_n=1, spi_sclk=0, busy=0, rx_valid=0, overflow=0, rx_word=0.
- R2: The host_sel code sets the frame length: 0 gives 1 byte, 1 gives 2, 2 gives 3, 3 gives 4. The frame has exactly 8 rising spi_sclk edges per byte while spi_cs_n is low. Bytes of host_wdata above the selected count are never sent.
- R3: Bytes leave in the order host_wdata[7:0], [15:8], [23:16], [31:24], and each byte is sent most significant bit first.
- R4: SPI mode 0. spi_sclk idles low and is high only while spi_cs_n is low. spi_mosi changes only while spi_sclk is low, and a receiving device samples it on the rising edge.
- R5: spi_miso is sampled at each rising edge, most significant bit first. For an n-byte frame, the i-th received byte (i=0 first) lands in lane 4-n+i of rx_word (lane k = bits [8k+7:8k]). rx_word changes only in the cycle spi_cs_n rises.
- R6: rx_word lanes below lane 4-n keep their earlier values.
- R7: busy rises in the cycle after an accepted host_wr and falls in the same cycle that spi_cs_n rises. spi_cs_n is low only while busy is high.
- R8: A host_wr while busy=1 starts nothing. It sets overflow, which stays set until reset.
- R9: rx_valid rises in the cycle spi_cs_n rises and is cleared by host_rd. If host_rd falls in the completion cycle, rx_valid ends up set.
- R10: One spi_sclk period lasts 2*H system clocks, where H is sclk_half_div. A value of 0 is treated as 1. The value is taken when the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_half_div | input | 8 | Serial clock half period in system clocks |
| host_wr | input | 1 | Write strobe, starts a frame when idle |
| host_sel | input | 2 | Byte count select (count minus one) |
| host_wdata | input | 32 | Word to send |
| host_rd | input | 1 | Read strobe, clears rx_valid |
| rx_word | output | 32 | Packed receive word |
| rx_valid | output | 1 | New receive word available |
| busy | output | 1 | Frame in progress |
| overflow | output | 1 | Sticky: a write was dropped |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Completion of a frame and a host read of the receive word can fall in the same clock cycle. The completion sets rx_valid while the read clears it. With the half period set to 1, a one-byte frame completes exactly 17 cycles after the accepted write. The bench first clears rx_valid, then raises host_rd so that it is sampled on that seventeenth edge. It judges the outcome by rx_valid being 1 and spi_cs_n being high just after that edge, having seen rx_valid still 0 one cycle before.

// File: rtl/spi_packer_pkg.sv
`timescale 1ns/1ps
package spi_packer_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_LOW,
    PH_TAIL
  } phase_e;
endpackage

// File: rtl/spi_tick_gen.sv
`timescale 1ns/1ps
// Half-period tick generator for the serial clock.
module spi_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == half_q - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= DIV_W'(1);
      cnt_q  <= '0;
    end else if (restart) begin
      half_q <= (half_div == '0) ? DIV_W'(1) : half_div;
      cnt_q  <= '0;
    end else if (run) begin
      cnt_q <= wrap ? '0 : cnt_q + DIV_W'(1);
    end
  end

  assign tick = run && !restart && wrap;
endmodule

// File: rtl/spi_shift_core.sv
`timescale 1ns/1ps
// Frame sequencer: chip select, serial clock and data-out shifter (mode 0).
module spi_shift_core
  import spi_packer_pkg::*;
#(
  parameter int  DATA_W = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int NB_W   = $clog2(BYTES) + 1,
  localparam int BITS_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NB_W-1:0]   nbytes,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tick,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  output logic              sample,
  output logic              done
);
  phase_e            ph_q;
  logic [DATA_W-1:0] sreg_q;
  logic [BITS_W-1:0] bits_q;
  logic [DATA_W-1:0] tx_ordered;

  // Lowest byte goes to the top so that a left shift emits it first.
  for (genvar g = 0; g < BYTES; g++) begin : g_order
    assign tx_ordered[DATA_W-1-8*g -: 8] = tx_word[8*g +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      sclk   <= 1'b0;
      cs_n   <= 1'b1;
      mosi   <= 1'b0;
      sreg_q <= '0;
      bits_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (start) begin
            sreg_q <= tx_ordered;
            mosi   <= tx_ordered[DATA_W-1];
            bits_q <= BITS_W'({nbytes, 3'b000});
            cs_n   <= 1'b0;
            sclk   <= 1'b0;
            ph_q   <= PH_SETUP;
          end
        end
        PH_SETUP, PH_LOW: begin
          if (tick) begin
            sclk <= 1'b1;
            ph_q <= PH_HIGH;
          end
        end
        PH_HIGH: begin
          if (tick) begin
            sclk   <= 1'b0;
            bits_q <= bits_q - BITS_W'(1);
            if (bits_q == BITS_W'(1)) begin
              ph_q <= PH_TAIL;
            end else begin
              sreg_q <= sreg_q << 1;
              mosi   <= sreg_q[DATA_W-2];
              ph_q   <= PH_LOW;
            end
          end
        end
        PH_TAIL: begin
          if (tick) begin
            cs_n <= 1'b1;
            ph_q <= PH_IDLE;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign sample = tick && ((ph_q == PH_SETUP) || (ph_q == PH_LOW));
  assign done   = tick && (ph_q == PH_TAIL);
endmodule

// File: rtl/spi_rx_pack.sv
`timescale 1ns/1ps
// Collects data-in bits into bytes and merges them into the top lanes.
module spi_rx_pack #(
  parameter int  DATA_W = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int NB_W   = $clog2(BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NB_W-1:0]   nbytes,
  input  logic              sample,
  input  logic              miso,
  input  logic              done,
  output logic [DATA_W-1:0] rx_word
);
  logic [NB_W-1:0]   nb_q;
  logic [2:0]        bitc_q;
  logic [7:0]        byte_q;
  logic [DATA_W-1:0] acc_q;
  logic [7:0]        byte_nxt;
  logic [DATA_W-1:0] lane_mask;

  assign byte_nxt = {byte_q[6:0], miso};

  // Lane g is filled when it is among the top nb_q lanes.
  for (genvar g = 0; g < BYTES; g++) begin : g_mask
    assign lane_mask[8*g +: 8] = {8{(BYTES - g) <= int'(nb_q)}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nb_q    <= '0;
      bitc_q  <= '0;
      byte_q  <= '0;
      acc_q   <= '0;
      rx_word <= '0;
    end else begin
      if (start) begin
        nb_q   <= nbytes;
        bitc_q <= '0;
      end else if (sample) begin
        byte_q <= byte_nxt;
        bitc_q <= bitc_q + 3'd1;
        if (bitc_q == 3'd7) begin
          acc_q <= {byte_nxt, acc_q[DATA_W-1:8]};
        end
      end
      if (done) begin
        rx_word <= (acc_q & lane_mask) | (rx_word & ~lane_mask);
      end
    end
  end
endmodule

// File: rtl/spi_word_packer.sv
`timescale 1ns/1ps
// Top: host handshake flags around the frame sequencer and receive packer.
module spi_word_packer #(
  parameter int  DATA_W = 32,
  parameter int  DIV_W  = 8,
  localparam int BYTES  = DATA_W / 8,
  localparam int SEL_W  = $clog2(BYTES),
  localparam int NB_W   = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  sclk_half_div,
  input  logic              host_wr,
  input  logic [SEL_W-1:0]  host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              busy,
  output logic              overflow,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic            accept;
  logic [NB_W-1:0] nbytes;
  logic            tick;
  logic            sample;
  logic            done;

  assign accept = host_wr && !busy;
  assign nbytes = NB_W'(host_sel) + NB_W'(1);

  spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .restart  (accept),
    .run      (busy),
    .half_div (sclk_half_div),
    .tick     (tick)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .nbytes  (nbytes),
    .tx_word (host_wdata),
    .tick    (tick),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .sample  (sample),
    .done    (done)
  );

  spi_rx_pack #(.DATA_W(DATA_W)) u_pack (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .nbytes  (nbytes),
    .sample  (sample),
    .miso    (spi_miso),
    .done    (done),
    .rx_word (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      overflow <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      if (accept)    busy <= 1'b1;
      else if (done) busy <= 1'b0;
      if (host_wr && busy) overflow <= 1'b1;
      if (done)         rx_valid <= 1'b1;
      else if (host_rd) rx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_word_packer_chk.sv
`timescale 1ns/1ps
module spi_word_packer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic              busy,
  input logic              overflow,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_word,
  input logic              spi_sclk,
  input logic              spi_cs_n,
  input logic              spi_mosi
);
  assert_cs_needs_busy_R7: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> busy);

  assert_sclk_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> !spi_cs_n);

  assert_mosi_steady_high_R4: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> $stable(spi_mosi));

  assert_no_overflow_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (host_wr && busy) |=> overflow);

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_valid_at_close_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_valid) |-> $rose(spi_cs_n));

  assert_word_only_at_close_R5: assert property (@(posedge clk) disable iff (rst)
    !$rose(spi_cs_n) |-> $stable(rx_word));
endmodule

bind spi_word_packer spi_word_packer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .host_wr  (host_wr),
  .busy     (busy),
  .overflow (overflow),
  .rx_valid (rx_valid),
  .rx_word  (rx_word),
  .spi_sclk (spi_sclk),
  .spi_cs_n (spi_cs_n),
  .spi_mosi (spi_mosi)
);

// File: tb/spi_word_packer_test.sv
`timescale 1ns/1ps
module spi_word_packer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  sclk_half_div = 8'd2;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic        host_rd = 1'b0;
  logic [31:0] rx_word;
  logic        rx_valid, busy, overflow;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;
  int unsigned cyc = 0;

  spi_word_packer uut (
    .clk(clk), .rst(rst), .sclk_half_div(sclk_half_div),
    .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
    .host_rd(host_rd), .rx_word(rx_word), .rx_valid(rx_valid),
    .busy(busy), .overflow(overflow), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #4 clk = ~clk;

  // Flash model: response bytes presented MSB first, first byte earliest.
  logic [31:0] slv_load = '0;
  logic [31:0] slv_sr = '0;
  logic [31:0] mos_sr = '0;
  int          edges = 0;
  time         t_r1 = 0, t_r2 = 0;
  int          mosi_viol = 0;
  logic        prev_sclk = 1'b0, prev_mosi = 1'b0;
  logic [31:0] model_rx = '0;

  always @(negedge spi_cs_n) begin
    slv_sr   = slv_load;
    spi_miso = slv_sr[31];
    mos_sr   = '0;
    edges    = 0;
  end
  always @(negedge spi_sclk) begin
    slv_sr   = slv_sr << 1;
    spi_miso = slv_sr[31];
  end
  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (edges == 0) t_r1 = $time;
      if (edges == 1) t_r2 = $time;
      mos_sr = {mos_sr[30:0], spi_mosi};
      edges  = edges + 1;
    end
  end
  always @(negedge clk) begin
    if (!rst && prev_sclk && spi_sclk && (spi_mosi != prev_mosi)) mosi_viol++;
    prev_sclk = spi_sclk;
    prev_mosi = spi_mosi;
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      finish_run();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk);
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (busy) check("R7 frame timeout busy", 32'(busy), 32'd0);
  endtask

  task automatic write_word(input logic [1:0] sel, input logic [31:0] wd);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = wd;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  function automatic logic [31:0] exp_mosi(input int n, input logic [31:0] wd);
    logic [31:0] e = '0;
    for (int i = 0; i < n; i++) e = (e << 8) | 32'(wd[8*i +: 8]);
    return e;
  endfunction

  function automatic logic [31:0] exp_rx(input logic [31:0] prev, input int n, input logic [31:0] resp);
    logic [31:0] r = prev;
    for (int i = 0; i < n; i++) r[8*(4-n+i) +: 8] = resp[31-8*i -: 8];
    return r;
  endfunction

  task automatic xfer(input string tag, input logic [1:0] sel, input logic [31:0] wd, input logic [31:0] resp);
    int n = int'(sel) + 1;
    slv_load = resp;
    write_word(sel, wd);
    check({tag, " R7 busy after write"}, 32'(busy), 32'd1);
    check({tag, " R7 cs low in frame"}, 32'(spi_cs_n), 32'd0);
    wait_idle();
    model_rx = exp_rx(model_rx, n, resp);
    check({tag, " R2 edge count"}, 32'(edges), 32'(8*n));
    check({tag, " R3 mosi bytes"}, mos_sr, exp_mosi(n, wd));
    check({tag, " R5/R6 rx word"}, rx_word, model_rx);
    check({tag, " R9 rx_valid set"}, 32'(rx_valid), 32'd1);
    check({tag, " R4 idle pins"}, {30'd0, spi_cs_n, spi_sclk}, 32'd2);
  endtask

  task automatic t_reset();
    check("R1 cs_n", 32'(spi_cs_n), 32'd1);
    check("R1 sclk", 32'(spi_sclk), 32'd0);
    check("R1 flags", {29'd0, busy, rx_valid, overflow}, 32'd0);
    check("R1 rx_word", rx_word, 32'd0);
  endtask

  task automatic t_lengths();
    xfer("4B", 2'd3, 32'h1122_3344, 32'hA1B2_C3D4);
    xfer("1B wren", 2'd0, 32'hA5A5_A506, 32'h5C00_0000);
    xfer("2B rdsr", 2'd1, 32'h1234_DD05, 32'h0003_0000);
    xfer("3B", 2'd2, 32'hFF77_8899, 32'hE1E2_E300);
  endtask

  task automatic t_read_clears();
    @(negedge clk) host_rd = 1'b1;
    @(negedge clk) host_rd = 1'b0;
    check("R9 read clears rx_valid", 32'(rx_valid), 32'd0);
    check("R9 read keeps rx_word", rx_word, model_rx);
  endtask

  task automatic t_overflow();
    slv_load = 32'h6600_0000;
    write_word(2'd1, 32'h0000_AB05);
    repeat (3) @(negedge clk);
    host_wr = 1'b1; host_sel = 2'd0; host_wdata = 32'h0000_00FF;
    @(negedge clk) host_wr = 1'b0;
    check("R8 overflow set", 32'(overflow), 32'd1);
    wait_idle();
    model_rx = exp_rx(model_rx, 2, 32'h6600_0000);
    check("R8 dropped write not sent", mos_sr, 32'h0000_05AB);
    check("R8 edge count of kept frame", 32'(edges), 32'd16);
    repeat (5) @(negedge clk);
    check("R8 no second frame", {30'd0, busy, spi_cs_n}, 32'd1);
    xfer("after ovf", 2'd0, 32'h0000_0042, 32'h9900_0000);
    check("R8 overflow sticky", 32'(overflow), 32'd1);
  endtask

  task automatic t_divider();
    sclk_half_div = 8'd3;
    xfer("div3", 2'd0, 32'h0000_0081, 32'h1800_0000);
    check("R10 period half=3", 32'(t_r2 - t_r1), 32'd48);
    sclk_half_div = 8'd0;
    xfer("div0", 2'd0, 32'h0000_0018, 32'h8100_0000);
    check("R10 period half=0 as 1", 32'(t_r2 - t_r1), 32'd16);
  endtask

  task automatic t_coincide();
    sclk_half_div = 8'd1;
    t_read_clears();
    slv_load = 32'h3C00_0000;
    @(negedge clk);
    host_wr = 1'b1; host_sel = 2'd0; host_wdata = 32'h0000_0006;
    @(posedge clk);
    @(negedge clk) host_wr = 1'b0;
    repeat (16) @(posedge clk);
    @(negedge clk);
    check("R9 not valid before close", {30'd0, rx_valid, spi_cs_n}, 32'd0);
    host_rd = 1'b1;
    @(posedge clk);
    @(negedge clk) host_rd = 1'b0;
    model_rx = exp_rx(model_rx, 1, 32'h3C00_0000);
    check("R9 completion wins over read", {30'd0, rx_valid, spi_cs_n}, 32'd3);
    check("R5 word at close", rx_word, model_rx);
    t_read_clears();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_read_clears();
    t_overflow();
    t_divider();
    t_coincide();
    check("R4 mosi steady while sclk high", 32'(mosi_viol), 32'd0);
    finish_run();
  end
endmodule